// File: doc/BRIEF.md
# Separate-I/O Double-Data-Rate Two-Word Burst SRAM Model

This block is a synthesizable behavioural model of a static memory with separate read and write data buses. Every address holds a burst of two words. Because read data leaves on its own output bus and write data arrives on its own input bus, neither bus ever turns around. The two ports share one address bus. A read address is taken on the K-rise phase and a write address on the K-fall phase of the same K cycle, so each port gets one burst per K cycle.

The model runs on one internal clock at twice the K rate, and only its rising edges are used. Each clock edge is one half of a K cycle. After reset the block owns the phase and drives `kSlot` high in every clock cycle whose closing edge is a K-rise edge. The source aligns its commands and data to that output. Write data is captured on both phases, so it moves two words per K cycle. Read data is driven on both phases. A valid strobe rises and falls with the read words, so a consumer can capture them without knowing the latency setting.

A static mode input selects the read latency: 1.5 K cycles (three phases) or 1 K cycle (two phases). If a read and a write in the same K cycle target the same address, the read returns the words being written. The word width and the address width are parameters. Both 18-bit and 36-bit words are intended.

Top module: `ddr_sio_burst_sram`

## Requirements
- R1: In the first clock cycle after reset is released, `kSlot` is 1, `echoValid` is 0 and `rdData` is zero.
- R2: `kSlot` toggles on every clock edge. A clock edge that closes a cycle with `kSlot`=1 is a K-rise edge; the next edge is a K-fall edge.
- R3: If `wrSelN` is 0 at a K-rise edge, `wrData` at that edge is burst word 0. At the following K-fall edge, `addr` is the write address and `wrData` is burst word 1, and both words are stored at that address.
- R4: If `rdSelN` is 0 at a K-rise edge, `addr` at that edge is the read address. The burst comes out on `rdData` as word 0 and then word 1 on consecutive clock cycles, with `echoValid` at 1 for both.
- R5: With `longLatency`=1, a read captured at clock edge n shows word 0 after edge n+3 and word 1 after edge n+4.
- R6: With `longLatency`=0, a read captured at clock edge n shows word 0 after edge n+2 and word 1 after edge n+3.
- R7: A port whose select is 1 at its K-rise edge does nothing. A deselected read produces no burst. A deselected write leaves the stored words unchanged.
- R8: When a read and a write in the same K cycle target the same address, the read returns the two words written in that K cycle.
- R9: `rdData` is all zeros in every cycle in which `echoValid` is 0.
- R10: Reads issued in consecutive K cycles produce an unbroken stream on `rdData` with `echoValid` held high. Every burst lasts exactly two cycles.
- R11: The lowest address (0) and the highest address (all ones) store and return their bursts independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| longLatency | input | 1 | 1: read latency 1.5 K cycles, 0: 1 K cycle; change only when no read is in flight |
| addr | input | ADDR_W | Shared address: read address on K-rise, write address on K-fall |
| rdSelN | input | 1 | Active-low read select, sampled on K-rise |
| wrSelN | input | 1 | Active-low write select, sampled on K-rise |
| wrData | input | WORD_W | Write data: word 0 on K-rise, word 1 on K-fall |
| kSlot | output | 1 | High when the next clock edge is a K-rise edge |
| rdData | output | WORD_W | Read data, one burst word per clock cycle |
| echoValid | output | 1 | High in each cycle in which `rdData` carries a read word |

## Verification
Assertions check these rules on every cycle: the phase alternation, that a write commit always follows a captured word 0, and that a read fetch always follows a captured read address. They also check the exact cycle offset of the valid strobe in each latency mode, that a burst always lasts two cycles, and that the data bus is zero when idle. Whether the stored words are correct can only be shown by the bench's scenarios. These cover:
- write-through on a shared address,
- that deselected writes leave the array alone,
- that the lowest and highest addresses do not alias,
- that output streams stay unbroken in both latency modes.

// File: rtl/ddr_sio_pkg.sv
package ddr_sio_pkg;

  // Words per address; the datapath lane structure follows this count.
  localparam int BURST_LEN = 2;

  // Strobes from control to datapath, one bit each.
  typedef struct packed {
    logic capRdAddr;   // latch the read address (K-rise)
    logic capWord0;    // latch write word 0 (K-rise)
    logic commitWr;    // write both lanes using addr on the K-fall edge
    logic fetchRd;     // read the array (with forwarding) into stage A
    logic loadFirst;   // drive word 0 of the selected stage
    logic loadSecond;  // drive the held word 1
    logic useStageB;   // long latency: take the extra-delay stage
  } ctrlStrobes_t;

endpackage

// File: rtl/ddr_sio_ctrl.sv
module ddr_sio_ctrl
  import ddr_sio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdSelN,
  input  logic         wrSelN,
  input  logic         longLatency,
  output logic         kSlot,
  output logic         echoValid,
  output ctrlStrobes_t strobes
);

  logic phaseQ;
  logic rdPendQ;
  logic wrPendQ;
  logic stageAV;
  logic stageBV;
  logic secondQ;
  logic echoQ;
  logic firstV;

  // phaseQ==0: the coming edge is a K-rise edge.
  assign kSlot = ~phaseQ;
  assign firstV = longLatency ? stageBV : stageAV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      rdPendQ <= 1'b0;
      wrPendQ <= 1'b0;
      stageAV <= 1'b0;
      stageBV <= 1'b0;
      secondQ <= 1'b0;
      echoQ   <= 1'b0;
    end else begin
      phaseQ <= ~phaseQ;
      if (kSlot) begin
        rdPendQ <= ~rdSelN;
        wrPendQ <= ~wrSelN;
      end else begin
        rdPendQ <= 1'b0;
        wrPendQ <= 1'b0;
      end
      stageAV <= strobes.fetchRd;
      stageBV <= stageAV;
      secondQ <= firstV;
      echoQ   <= firstV | secondQ;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.capRdAddr  = kSlot & ~rdSelN;
    strobes.capWord0   = kSlot & ~wrSelN;
    strobes.commitWr   = ~kSlot & wrPendQ;
    strobes.fetchRd    = ~kSlot & rdPendQ;
    strobes.loadFirst  = firstV;
    strobes.loadSecond = secondQ;
    strobes.useStageB  = longLatency;
  end

  assign echoValid = echoQ;

  AST_PHASE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    kSlot |=> !kSlot); // R2
  AST_PHASE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !kSlot |=> kSlot); // R2
  AST_LONG_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (kSlot && !rdSelN && longLatency) |-> ##4 echoValid ##1 echoValid); // R5
  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (kSlot && !rdSelN && !longLatency) |-> ##3 echoValid ##1 echoValid); // R6
  AST_BURST_TWO_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(echoValid) |=> echoValid); // R10

endmodule

// File: rtl/ddr_sio_datapath.sv
module ddr_sio_datapath
  import ddr_sio_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = BURST_LEN;

  logic [ADDR_W-1:0]             rdAddrQ;
  logic [WORD_W-1:0]             word0Q;
  logic [WORD_W-1:0]             secondWordQ;
  logic [WORD_W-1:0]             rdDataQ;
  logic                          fwdHit;
  logic [LANES-1:0][WORD_W-1:0]  wrLane;
  logic [LANES-1:0][WORD_W-1:0]  srcLane;

  // Lane 0 was latched on K-rise; lane 1 is on the bus at the K-fall commit.
  assign wrLane[0] = word0Q;
  assign wrLane[1] = wrData;

  // Same-K-cycle write to the read address: hand the new words straight over.
  assign fwdHit = strobes.commitWr && (addr == rdAddrQ);

  always_ff @(posedge clk) begin
    if (strobes.capRdAddr) rdAddrQ <= addr;
    if (strobes.capWord0)  word0Q  <= wrData;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WORD_W-1:0] bankQ [DEPTH];
    logic [WORD_W-1:0] fetchWord;
    logic [WORD_W-1:0] stageAQ;
    logic [WORD_W-1:0] stageBQ;

    always_ff @(posedge clk) begin
      if (strobes.commitWr) bankQ[addr] <= wrLane[g];
    end

    assign fetchWord = fwdHit ? wrLane[g] : bankQ[rdAddrQ];

    always_ff @(posedge clk) begin
      if (strobes.fetchRd) stageAQ <= fetchWord;
      stageBQ <= stageAQ;
    end

    assign srcLane[g] = strobes.useStageB ? stageBQ : stageAQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondWordQ <= '0;
      rdDataQ     <= '0;
    end else begin
      if (strobes.loadFirst) secondWordQ <= srcLane[1];
      if (strobes.loadFirst)       rdDataQ <= srcLane[0];
      else if (strobes.loadSecond) rdDataQ <= secondWordQ;
      else                         rdDataQ <= '0;
    end
  end

  assign rdData = rdDataQ;

  AST_COMMIT_AFTER_WORD0: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWr |-> $past(strobes.capWord0)); // R3
  AST_FETCH_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchRd |-> $past(strobes.capRdAddr)); // R4

endmodule

// File: rtl/ddr_sio_burst_sram.sv
module ddr_sio_burst_sram
  import ddr_sio_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              longLatency,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [WORD_W-1:0] wrData,
  output logic              kSlot,
  output logic [WORD_W-1:0] rdData,
  output logic              echoValid
);

  ctrlStrobes_t strobes;

  ddr_sio_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdSelN      (rdSelN),
    .wrSelN      (wrSelN),
    .longLatency (longLatency),
    .kSlot       (kSlot),
    .echoValid   (echoValid),
    .strobes     (strobes)
  );

  ddr_sio_datapath #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrData  (wrData),
    .strobes (strobes),
    .rdData  (rdData)
  );

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !echoValid |-> (rdData == '0)); // R9

endmodule

// File: tb/ddr_sio_burst_sram_bench.sv
module ddr_sio_burst_sram_bench;

  localparam int W  = 18;
  localparam int AW = 6;

  typedef struct {
    logic [W-1:0] data;
    int           cyc;
    string        req;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          longLatency = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rdSelN = 1'b1;
  logic          wrSelN = 1'b1;
  logic [W-1:0]  wrData = '0;
  logic          kSlot;
  logic [W-1:0]  rdData;
  logic          echoValid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [W-1:0] refMem [1<<AW][2];
  item_t expQ[$];

  ddr_sio_burst_sram #(.WORD_W(W), .ADDR_W(AW)) u_ddr_sio_burst_sram (
    .clk(clk), .rstN(rstN), .longLatency(longLatency), .addr(addr),
    .rdSelN(rdSelN), .wrSelN(wrSelN), .wrData(wrData), .kSlot(kSlot),
    .rdData(rdData), .echoValid(echoValid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One K cycle: K-rise carries read addr / write word 0, K-fall carries write addr / word 1.
  task automatic doK(input bit rd, input logic [AW-1:0] ra, input bit wr,
                     input logic [AW-1:0] wa, input logic [W-1:0] w0,
                     input logic [W-1:0] w1, input string req);
    int lat;
    @(negedge clk);
    if (!kSlot) @(negedge clk);
    lat = longLatency ? 3 : 2;
    rdSelN = !rd; wrSelN = !wr; addr = ra; wrData = w0;
    if (wr) begin refMem[wa][0] = w0; refMem[wa][1] = w1; end
    if (rd) begin
      expQ.push_back('{refMem[ra][0], cyc + 1 + lat, req});
      expQ.push_back('{refMem[ra][1], cyc + 2 + lat, req});
    end
    @(negedge clk);
    rdSelN = 1'b1; wrSelN = 1'b1; addr = wa; wrData = w1;
  endtask

  task automatic idleK(input int n);
    for (int i = 0; i < n; i++) doK(1'b0, '0, 1'b0, '0, '0, '0, "idle");
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN) begin
      if (echoValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7", "unexpected read word", 64'(rdData), 64'd0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk(rdData == it.data, it.req, "read word", 64'(rdData), 64'(it.data));
          chk(cyc == it.cyc, it.req, "word timing (R5/R6)", 64'(cyc), 64'(it.cyc));
        end
      end else begin
        chk(rdData == '0, "R9", "idle rdData", 64'(rdData), 64'd0);
      end
    end
  end

  // Watchdog.
  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(kSlot == 1'b1, "R1", "kSlot after reset", 64'(kSlot), 64'd1);
    chk(echoValid == 1'b0, "R1", "echoValid after reset", 64'(echoValid), 64'd0);
    chk(rdData == '0, "R1", "rdData after reset", 64'(rdData), 64'd0);
    @(negedge clk);
    // R2 phase alternates
    chk(kSlot == 1'b0, "R2", "kSlot second cycle", 64'(kSlot), 64'd0);

    // Long latency: back-to-back writes, then back-to-back reads (R3, R4, R5, R10).
    for (int a = 0; a < 8; a++)
      doK(1'b0, '0, 1'b1, AW'(a), W'(18'h100 + a), W'(18'h2A000 + a), "R3");
    doK(1'b0, '0, 1'b1, '1, 18'h3FFFF, 18'h15555, "R11");
    doK(1'b0, '0, 1'b1, '0, 18'h0A0A0, 18'h05050, "R11");
    for (int a = 1; a < 8; a++)
      doK(1'b1, AW'(a), 1'b0, '0, '0, '0, "R10");
    doK(1'b1, '1, 1'b0, '0, '0, '0, "R11");
    doK(1'b1, '0, 1'b0, '0, '0, '0, "R11");
    // Interleaved read and write to different addresses (R4, R3).
    for (int a = 0; a < 4; a++)
      doK(1'b1, AW'(a + 1), 1'b1, AW'(a + 20), W'(18'h30000 + a), W'(18'h0F000 + a), "R4");
    for (int a = 0; a < 4; a++)
      doK(1'b1, AW'(a + 20), 1'b0, '0, '0, '0, "R3");
    // Write-through on same address in same K cycle (R8).
    doK(1'b1, 6'd9, 1'b1, 6'd9, 18'h12345, 18'h2ABCD, "R8");
    // Deselected write leaves address 3 alone; deselected read yields nothing (R7).
    doK(1'b0, 6'd5, 1'b0, 6'd3, 18'h3DEAD, 18'h3BEEF, "R7");
    idleK(1);
    doK(1'b1, 6'd3, 1'b0, '0, '0, '0, "R7");
    idleK(4);

    // Short latency (R6).
    @(negedge clk);
    longLatency = 1'b0;
    for (int a = 0; a < 8; a++)
      doK(1'b1, AW'(a), 1'b0, '0, '0, '0, "R6");
    doK(1'b1, 6'd9, 1'b1, 6'd9, 18'h01111, 18'h02222, "R8");
    doK(1'b1, 6'd30, 1'b1, 6'd30, 18'h03333, 18'h04444, "R8");
    doK(1'b1, '1, 1'b1, 6'd2, 18'h05555, 18'h06666, "R11");
    doK(1'b1, 6'd2, 1'b0, '0, '0, '0, "R6");
    idleK(4);

    chk(expQ.size() == 0, "R4", "all bursts returned", 64'(expQ.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule